// File: doc/BRIEF.md
# Canonical Address Checker and Router

This block sits between the GPU engines and the translation hardware. Each engine request carries a 64-bit virtual address. Only 48 of those bits are translated. Bits 63 down to 48 must be copies of bit 47 for the address to count as canonical. The block does three things with each request:

- It rejects any address in the gap between the two canonical halves. Such an address raises a range fault that reports the full 64-bit value.
- It passes every other address on as a 48-bit linear address, together with its 4 KiB page frame number.
- It picks the consumer of each accepted request. Normally the local page-table walker gets it. When the address-translation-cache path is enabled, requests in the lower canonical half go to the port that leads to the host CPU / IOMMU translation instead.

Each output is a one-entry register slot with a valid/ready handshake. A request waits in its slot until the consumer takes it. The input stalls while a request waits. The routing choice is made once, at the moment the request is accepted.

Top module: `canon_route`

## Requirements
- R1: An address is canonical when bits 63..48 all equal bit 47. A canonical request is forwarded to exactly one output port. A non-canonical request is forwarded to neither port.
- R2: In the cycle after a non-canonical request is accepted, `fault_pulse` is high for exactly one cycle (unless another fault follows), and `fault_addr` holds the complete 64-bit address.
- R3: `fault_sticky` is set by every fault and stays set until `fault_clr` is seen high at a clock edge. A fault at the same edge as `fault_clr` leaves the bit set.
- R4: The walker port carries the address with bits 63..48 removed (`walk_addr` = address[47:0]) and `walk_pfn` = address[47:12].
- R5: With `atc_en` high, a canonical address with bit 47 = 0 goes to the ATC port, with `atc_addr` = address[47:0]. The walker port is not used.
- R6: With `atc_en` low, a canonical address with bit 47 = 0 goes to the walker port.
- R7: A canonical address with bit 47 = 1 always goes to the walker port, whatever the value of `atc_en`.
- R8: While an output's valid is high and its ready is low, that output's data does not change and `req_ready` is low.
- R9: `atc_en` is sampled only at the edge where a request is accepted. Changing it while a request waits does not move that request to the other port.
- R10: A synchronous active-high `rst` clears both output valids, `fault_pulse` and `fault_sticky`.
- R11: An output's valid rises in the cycle after acceptance. When the consumers are ready, one request per cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| atc_en | input | 1 | Route the lower canonical half to the ATC port |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_addr | input | 64 | Virtual address of the request |
| walk_valid | output | 1 | Walker port request valid |
| walk_ready | input | 1 | Walker accepts request |
| walk_addr | output | 48 | Linear address to the walker |
| walk_pfn | output | 36 | Page frame number to the walker |
| atc_valid | output | 1 | ATC port request valid |
| atc_ready | input | 1 | ATC path accepts request |
| atc_addr | output | 48 | Linear address to the ATC path |
| fault_pulse | output | 1 | One-cycle range-fault indication |
| fault_addr | output | 64 | Full address of the last fault |
| fault_sticky | output | 1 | Fault status, held until cleared |
| fault_clr | input | 1 | Clears the fault status |

## Verification
The properties assume these things about the inputs:
- `req_valid`, `req_addr`, `atc_en` and both ready inputs are known values, sampled at the rising edge.
- A consumer may drop or raise ready in any cycle.
- The requester may change its address freely while it is being stalled.

The stimulus changes every input half a cycle away from the active edge, so each acceptance is decided by values that are already stable. The address sweep forms each address from a chosen top-16-bit pattern, bit 47 and low bits. The sweep is crossed with both settings of `atc_en`, so every routing and fault case is reached, including the first and last addresses on both sides of the gap. Separate sequences stall each port and toggle `atc_en` and `fault_clr` mid-wait.

// File: rtl/canon_route_pkg.sv
package canon_route_pkg;
  localparam int unsigned DEF_ADDR_W     = 64;
  localparam int unsigned DEF_VA_W       = 48;
  localparam int unsigned DEF_PAGE_SHIFT = 12;

  // output port index; order selects the slot in the generate loop
  typedef enum logic [0:0] {
    DEST_WALK = 1'b0,
    DEST_ATC  = 1'b1
  } dest_e;

  localparam int unsigned NUM_DEST = 2;
endpackage

// File: rtl/canon_classify.sv
module canon_classify #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned VA_W   = 48
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              atc_en,
  output logic              canonical,
  output logic              to_atc,
  output logic [VA_W-1:0]   linear
);
  localparam int unsigned EXT_W = ADDR_W - VA_W + 1;

  logic [EXT_W-1:0] ext_bits;

  always_comb begin
    ext_bits  = addr[ADDR_W-1:VA_W-1];
    // sign-extension test: all ones or all zeros across bit VA_W-1 and above
    canonical = (&ext_bits) | ~(|ext_bits);
    to_atc    = atc_en & ~addr[VA_W-1];
    linear    = addr[VA_W-1:0];
  end
endmodule

// File: rtl/canon_hold_reg.sv
module canon_hold_reg #(
  parameter int unsigned W = 48
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      dout <= din;
    end
  end
endmodule

// File: rtl/canon_fault_reg.sv
module canon_fault_reg #(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              clr,
  output logic              pulse,
  output logic [ADDR_W-1:0] addr_out,
  output logic              sticky
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse  <= 1'b0;
      sticky <= 1'b0;
    end else begin
      pulse <= set;
      if (set) begin
        sticky <= 1'b1;
      end else if (clr) begin
        sticky <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out <= '0;
    end else if (set) begin
      addr_out <= addr_in;
    end
  end
endmodule

// File: rtl/canon_route.sv
module canon_route
  import canon_route_pkg::*;
#(
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned VA_W       = DEF_VA_W,
  parameter int unsigned PAGE_SHIFT = DEF_PAGE_SHIFT
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   atc_en,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ADDR_W-1:0]      req_addr,
  output logic                   walk_valid,
  input  logic                   walk_ready,
  output logic [VA_W-1:0]        walk_addr,
  output logic [VA_W-PAGE_SHIFT-1:0] walk_pfn,
  output logic                   atc_valid,
  input  logic                   atc_ready,
  output logic [VA_W-1:0]        atc_addr,
  output logic                   fault_pulse,
  output logic [ADDR_W-1:0]      fault_addr,
  output logic                   fault_sticky,
  input  logic                   fault_clr
);
  localparam int unsigned NPORT = NUM_DEST;

  logic            is_canon;
  logic            go_atc;
  logic [VA_W-1:0] lin_addr;
  logic            accept;
  logic            slot_busy;
  logic            slot_fire;

  logic [NPORT-1:0] slot_load;
  logic [NPORT-1:0] slot_valid;
  logic [NPORT-1:0] slot_ready;
  logic [VA_W-1:0]  slot_data [NPORT];

  canon_classify #(
    .ADDR_W (ADDR_W),
    .VA_W   (VA_W)
  ) u_classify (
    .addr      (req_addr),
    .atc_en    (atc_en),
    .canonical (is_canon),
    .to_atc    (go_atc),
    .linear    (lin_addr)
  );

  // a single request may be in flight; a new one enters as the old one leaves
  always_comb begin
    slot_busy = |slot_valid;
    slot_fire = |(slot_valid & slot_ready);
    req_ready = ~slot_busy | slot_fire;
    accept    = req_valid & req_ready;
    slot_load = '0;
    slot_load[DEST_WALK] = accept & is_canon & ~go_atc;
    slot_load[DEST_ATC]  = accept & is_canon & go_atc;
  end

  assign slot_ready[DEST_WALK] = walk_ready;
  assign slot_ready[DEST_ATC]  = atc_ready;

  for (genvar p = 0; p < NPORT; p++) begin : g_slot
    canon_hold_reg #(
      .W (VA_W)
    ) u_hold (
      .clk   (clk),
      .rst   (rst),
      .load  (slot_load[p]),
      .din   (lin_addr),
      .ready (slot_ready[p]),
      .valid (slot_valid[p]),
      .dout  (slot_data[p])
    );
  end

  canon_fault_reg #(
    .ADDR_W (ADDR_W)
  ) u_fault (
    .clk      (clk),
    .rst      (rst),
    .set      (accept & ~is_canon),
    .addr_in  (req_addr),
    .clr      (fault_clr),
    .pulse    (fault_pulse),
    .addr_out (fault_addr),
    .sticky   (fault_sticky)
  );

  assign walk_valid = slot_valid[DEST_WALK];
  assign walk_addr  = slot_data[DEST_WALK];
  assign walk_pfn   = slot_data[DEST_WALK][VA_W-1:PAGE_SHIFT];
  assign atc_valid  = slot_valid[DEST_ATC];
  assign atc_addr   = slot_data[DEST_ATC];
endmodule

// File: rtl/canon_route_chk.sv
module canon_route_chk #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned VA_W   = 48
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              walk_valid,
  input logic              walk_ready,
  input logic [VA_W-1:0]   walk_addr,
  input logic              atc_valid,
  input logic              atc_ready,
  input logic [VA_W-1:0]   atc_addr,
  input logic              fault_pulse,
  input logic [ADDR_W-1:0] fault_addr,
  input logic              fault_sticky
);
  logic in_gap;
  assign in_gap = ~((&req_addr[ADDR_W-1:VA_W-1]) | ~(|req_addr[ADDR_W-1:VA_W-1]));

  p_fault_addr_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && in_gap) |=> (fault_pulse && fault_addr == $past(req_addr)));

  p_no_forward_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && in_gap) |=> (!walk_valid && !atc_valid));

  p_single_dest_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({walk_valid, atc_valid}));

  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    fault_pulse |-> fault_sticky);

  p_walk_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (walk_valid && !walk_ready) |=> (walk_valid && $stable(walk_addr)));

  p_atc_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (atc_valid && !atc_ready) |=> (atc_valid && $stable(atc_addr)));

  p_stall_r8: assert property (@(posedge clk) disable iff (rst)
    ((walk_valid && !walk_ready) || (atc_valid && !atc_ready)) |-> !req_ready);

  p_atc_lower_r5: assert property (@(posedge clk) disable iff (rst)
    atc_valid |-> !atc_addr[VA_W-1]);

  p_reset_r10: assert property (@(posedge clk)
    $past(rst) |-> (!walk_valid && !atc_valid && !fault_pulse && !fault_sticky));
endmodule

bind canon_route canon_route_chk #(
  .ADDR_W (ADDR_W),
  .VA_W   (VA_W)
) i_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_addr     (req_addr),
  .walk_valid   (walk_valid),
  .walk_ready   (walk_ready),
  .walk_addr    (walk_addr),
  .atc_valid    (atc_valid),
  .atc_ready    (atc_ready),
  .atc_addr     (atc_addr),
  .fault_pulse  (fault_pulse),
  .fault_addr   (fault_addr),
  .fault_sticky (fault_sticky)
);

// File: tb/test_canon_route.sv
module test_canon_route;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        atc_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        walk_valid;
  logic        walk_ready = 1'b1;
  logic [47:0] walk_addr;
  logic [35:0] walk_pfn;
  logic        atc_valid;
  logic        atc_ready = 1'b1;
  logic [47:0] atc_addr;
  logic        fault_pulse;
  logic [63:0] fault_addr;
  logic        fault_sticky;
  logic        fault_clr = 1'b0;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #2.5ns clk = ~clk;

  canon_route i_canon_route (
    .clk (clk), .rst (rst), .atc_en (atc_en),
    .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
    .walk_valid (walk_valid), .walk_ready (walk_ready),
    .walk_addr (walk_addr), .walk_pfn (walk_pfn),
    .atc_valid (atc_valid), .atc_ready (atc_ready), .atc_addr (atc_addr),
    .fault_pulse (fault_pulse), .fault_addr (fault_addr),
    .fault_sticky (fault_sticky), .fault_clr (fault_clr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  // present one request, wait for acceptance, end at the negedge after it
  task automatic send(input logic [63:0] a, input logic en);
    @(negedge clk);
    req_addr  = a;
    atc_en    = en;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [63:0] make_addr(input int ui, input logic b47, input int li);
    logic [15:0] up;
    logic [46:0] lo;
    case (ui)
      0: up = 16'h0000;
      1: up = 16'hFFFF;
      2: up = 16'h0001;
      3: up = 16'h8000;
      4: up = 16'h7FFF;
      default: up = 16'hFFFE;
    endcase
    case (li)
      0: lo = '0;
      1: lo = '1;
      default: lo = 47'h1234_5678_9ABC;
    endcase
    return {up, b47, lo};
  endfunction

  initial begin
    #(5ns * 150000);
    n_errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 walk_valid after reset", walk_valid, 0);
    check("R10 atc_valid after reset", atc_valid, 0);
    check("R10 fault_sticky after reset", fault_sticky, 0);
    check("R10 fault_pulse after reset", fault_pulse, 0);
    rst = 1'b0;

    // sweep: top patterns x bit 47 x low bits x atc_en
    for (int ui = 0; ui < 6; ui++)
      for (int b = 0; b < 2; b++)
        for (int li = 0; li < 3; li++)
          for (int e = 0; e < 2; e++) begin
            logic [63:0] a;
            logic canon, exp_atc, exp_walk;
            a = make_addr(ui, b[0], li);
            canon = (a[63:47] == '0) || (a[63:47] == '1);
            exp_atc  = canon && e[0] && !a[47];
            exp_walk = canon && !exp_atc;
            send(a, e[0]);
            check("R1 fault_pulse vs canonical", fault_pulse, !canon);
            check(a[47] ? "R7 walk_valid upper" : (e[0] ? "R5 walk_valid lower" : "R6 walk_valid lower"),
                  walk_valid, exp_walk);
            check("R5 atc_valid", atc_valid, exp_atc);
            if (exp_walk) begin
              check("R4 walk_addr", walk_addr, a[47:0]);
              check("R4 walk_pfn", walk_pfn, a[47:12]);
            end
            if (exp_atc) check("R5 atc_addr", atc_addr, a[47:0]);
            if (!canon) begin
              check("R2 fault_addr", fault_addr, a);
              check("R3 sticky set", fault_sticky, 1);
            end
            @(negedge clk);
            check("R2 fault pulse one cycle", fault_pulse, 0);
            check("R11 walk slot drained", walk_valid, 0);
          end

    // R3: clear, then fault coinciding with clear
    @(negedge clk); fault_clr = 1'b1;
    @(negedge clk); fault_clr = 1'b0;
    check("R3 sticky cleared", fault_sticky, 0);
    req_addr = 64'h0001_0000_0000_0000; req_valid = 1'b1; fault_clr = 1'b1;
    @(negedge clk); req_valid = 1'b0; fault_clr = 1'b0;
    check("R3 set wins over clear", fault_sticky, 1);
    check("R2 fault_addr with clear", fault_addr, 64'h0001_0000_0000_0000);

    // R8: walker stall, data stable, input stalled
    walk_ready = 1'b0;
    send(64'hFFFF_8000_0000_1000, 1'b0);
    req_addr = 64'hFFFF_FFFF_FFFF_F000; req_valid = 1'b1; atc_en = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8 req_ready low during stall", req_ready, 0);
      check("R8 walk_addr stable", walk_addr, 48'h8000_0000_1000);
    end
    walk_ready = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    check("R11 next request follows release", walk_addr, 48'hFFFF_FFFF_F000);
    check("R11 walk_valid on follow-up", walk_valid, 1);

    // R11: back-to-back acceptance
    @(negedge clk);
    req_addr = 64'h0000_0000_0000_5000; atc_en = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    check("R11 first of pair", walk_addr, 48'h5000);
    req_addr = 64'h0000_7FFF_FFFF_F000;
    @(negedge clk); req_valid = 1'b0;
    check("R11 second of pair", walk_addr, 48'h7FFF_FFFF_F000);
    check("R11 second valid", walk_valid, 1);
    @(negedge clk);

    // R9: atc_en change while ATC request waits
    atc_ready = 1'b0;
    send(64'h0000_0012_3456_7000, 1'b1);
    atc_en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 request stays on ATC", atc_valid, 1);
      check("R9 walker untouched", walk_valid, 0);
      check("R9 atc_addr held", atc_addr, 48'h0012_3456_7000);
    end
    atc_ready = 1'b1;
    @(negedge clk);
    check("R9 ATC drained", atc_valid, 0);
    check("R9 walker still idle", walk_valid, 0);

    // R10: reset while stalled with fault status set
    send(64'h8000_0000_0000_0000, 1'b0);
    walk_ready = 1'b0;
    send(64'hFFFF_8000_0000_0000, 1'b0);
    check("R10 precondition stalled", walk_valid, 1);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 walk_valid cleared", walk_valid, 0);
    check("R10 sticky cleared", fault_sticky, 0);
    walk_ready = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule